// File: doc/BRIEF.md
# Offcore Response Matcher and Latency Pair

This block holds two event counters that watch memory requests leaving a core. Each counter has its own match register, which holds a request-type mask, a supplier mask, a snoop-result mask, an any-response bit and an outstanding bit. In the normal per-response mode, a counter adds one for each completed request that passes its masks. The two counters then run independently of each other.

Counter 0 can instead run in outstanding-occupancy mode. In that mode it adds, every cycle, the number of requests of the selected types that are still in flight. To measure latency, software sets the same request mask on both counters. Counter 0 runs in outstanding mode and counter 1 runs with the any-response bit set. The ratio count0 / count1 then gives the average latency in core cycles. The division happens outside the block.

Software programs the match registers through a one-cycle write port. A write that breaks the configuration rules is rejected: the register keeps its old value and a one-cycle error pulse is raised. A write that is accepted clears the counter it selects.

Top module: `ofr_latency_pair`

## Requirements
- R1: After reset both counts read zero and cfgError is low.
- R2: A match word is laid out from bit 0 upward as follows: request mask (NUM_REQ bits), supplier mask (NUM_SUP bits), snoop mask (NUM_SNP bits), any-response bit, outstanding bit. An accepted write with cfgWrSel=0 updates counter 0 and cfgWrSel=1 updates counter 1. The write loads the register and clears that counter to zero on the same edge. The clear wins over an increment in that cycle, and the other counter is not affected.
- R3: In normal mode, a completion with cmpValid high adds exactly one to a counter on the next edge when all three hold: the cmpReq bit is set in the request mask, the cmpSup bit is set in the supplier mask, and the cmpSnp bit is set in the snoop mask. Otherwise the completion adds nothing.
- R4: When the any-response bit is set, the supplier and snoop masks are ignored. Every valid completion whose request type is in the request mask is counted.
- R5: When both the supplier mask and the snoop mask are zero, the counter behaves as if the any-response bit were set.
- R6: A write whose word sets the any-response bit together with a nonzero supplier or snoop mask is rejected. cfgError is high in the cycle after the write, the register keeps its old value, and the counter is not cleared.
- R7: A write that sets the outstanding bit is rejected in the same way as R6 when either of these holds: the word also has the any-response bit or a nonzero supplier or snoop mask, or the write targets counter 1.
- R8: With the outstanding bit set, counter 0 adds on every edge the sum of the occIn fields whose request type is in its request mask. It ignores completions. occIn holds one OCC_W-bit count per request type, with type 0 in the low bits.
- R9: A completion presented with cmpValid low changes neither count.
- R10: In the same cycle, counter 0 can take an occupancy update while counter 1 counts a completion. Both updates are applied.
- R11: cfgError is high only in the cycle right after a rejected write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Match-register write strobe |
| cfgWrSel | input | 1 | Selects counter 0 or counter 1 |
| cfgWrData | input | NUM_REQ+NUM_SUP+NUM_SNP+2 | Match word to be written |
| cmpValid | input | 1 | A request completes this cycle |
| cmpReq | input | $clog2(NUM_REQ) | Request-type index of the completion |
| cmpSup | input | $clog2(NUM_SUP) | Supplier index of the completion |
| cmpSnp | input | $clog2(NUM_SNP) | Snoop-result index of the completion |
| occIn | input | NUM_REQ*OCC_W | In-flight request count for each type |
| count0 | output | CNT_W | Counter 0 value |
| count1 | output | CNT_W | Counter 1 value |
| cfgError | output | 1 | Pulse: the previous write was rejected |

## Verification
The checker watches every cycle for four things:
- the error pulse only ever follows a write;
- an accepted write leaves the selected counter at zero;
- counter 1 holds still when nothing valid arrives, and never steps by more than one;
- counter 0 never steps by more than the largest possible occupancy sum.

Some properties cannot be seen from those invariants alone and are shown only by the bench scenarios:
- which completions actually pass a given set of masks;
- that any-response and empty masks override the other masks;
- that rejected words leave the old configuration working;
- that the two counters give the expected latency ratio together.

// File: rtl/ofr_pkg.sv
package ofr_pkg;
  typedef struct packed {
    logic [1:0] clr;      // clear counter n on this edge
    logic [1:0] occMode;  // counter n accumulates occupancy
  } ofrStrobes_t;
endpackage

// File: rtl/ofr_ctrl.sv
module ofr_ctrl
  import ofr_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int NUM_SUP = 4,
  parameter int NUM_SNP = 4,
  localparam int CFG_W = NUM_REQ + NUM_SUP + NUM_SNP + 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWrEn,
  input  logic                   cfgWrSel,
  input  logic [CFG_W-1:0]       cfgWrData,
  output logic [1:0][CFG_W-1:0]  cfgOut,
  output ofrStrobes_t            strobes,
  output logic                   cfgError
);
  localparam int SUP_LO = NUM_REQ;
  localparam int SNP_LO = SUP_LO + NUM_SUP;
  localparam int ANY_B  = SNP_LO + NUM_SNP;
  localparam int OUT_B  = ANY_B + 1;

  logic wrSupAny, wrSnpAny, wrAnyBit, wrOutBit, illegal, accept;

  always_comb begin
    wrSupAny = |cfgWrData[SUP_LO +: NUM_SUP];
    wrSnpAny = |cfgWrData[SNP_LO +: NUM_SNP];
    wrAnyBit = cfgWrData[ANY_B];
    wrOutBit = cfgWrData[OUT_B];
    illegal  = (wrAnyBit && (wrSupAny || wrSnpAny)) ||
               (wrOutBit && (wrAnyBit || wrSupAny || wrSnpAny || cfgWrSel));
    accept   = cfgWrEn && !illegal;
    strobes.clr[0]     = accept && !cfgWrSel;
    strobes.clr[1]     = accept && cfgWrSel;
    strobes.occMode[0] = cfgOut[0][OUT_B];
    strobes.occMode[1] = cfgOut[1][OUT_B];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgOut   <= '0;
      cfgError <= 1'b0;
    end else begin
      cfgError <= cfgWrEn && illegal;
      if (accept) cfgOut[cfgWrSel] <= cfgWrData;
    end
  end
endmodule

// File: rtl/ofr_datapath.sv
module ofr_datapath
  import ofr_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int NUM_SUP = 4,
  parameter int NUM_SNP = 4,
  parameter int OCC_W   = 4,
  parameter int CNT_W   = 48,
  localparam int CFG_W  = NUM_REQ + NUM_SUP + NUM_SNP + 2,
  localparam int REQ_IW = $clog2(NUM_REQ),
  localparam int SUP_IW = $clog2(NUM_SUP),
  localparam int SNP_IW = $clog2(NUM_SNP)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [1:0][CFG_W-1:0]  cfgIn,
  input  ofrStrobes_t            strobes,
  input  logic                   cmpValid,
  input  logic [REQ_IW-1:0]      cmpReq,
  input  logic [SUP_IW-1:0]      cmpSup,
  input  logic [SNP_IW-1:0]      cmpSnp,
  input  logic [NUM_REQ*OCC_W-1:0] occIn,
  output logic [1:0][CNT_W-1:0]  countOut
);
  localparam int SUP_LO = NUM_REQ;
  localparam int SNP_LO = SUP_LO + NUM_SUP;
  localparam int ANY_B  = SNP_LO + NUM_SNP;
  localparam int SUM_W  = OCC_W + REQ_IW + 1;

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    logic [NUM_REQ-1:0] reqMask;
    logic [NUM_SUP-1:0] supMask;
    logic [NUM_SNP-1:0] snpMask;
    logic               anyEff, hit;
    logic [SUM_W-1:0]   occSum;
    logic [CNT_W-1:0]   incr;

    always_comb begin
      reqMask = cfgIn[g][NUM_REQ-1:0];
      supMask = cfgIn[g][SUP_LO +: NUM_SUP];
      snpMask = cfgIn[g][SNP_LO +: NUM_SNP];
      anyEff  = cfgIn[g][ANY_B] || (supMask == '0 && snpMask == '0);
      hit     = cmpValid && reqMask[cmpReq] &&
                (anyEff || (supMask[cmpSup] && snpMask[cmpSnp]));
      occSum  = '0;
      for (int t = 0; t < NUM_REQ; t++)
        if (reqMask[t]) occSum = occSum + SUM_W'(occIn[t*OCC_W +: OCC_W]);
      incr = strobes.occMode[g] ? CNT_W'(occSum) : CNT_W'(hit);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                countOut[g] <= '0;
      else if (strobes.clr[g])  countOut[g] <= '0;
      else                      countOut[g] <= countOut[g] + incr;
    end
  end
endmodule

// File: rtl/ofr_latency_pair.sv
module ofr_latency_pair
  import ofr_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int NUM_SUP = 4,
  parameter int NUM_SNP = 4,
  parameter int OCC_W   = 4,
  parameter int CNT_W   = 48,
  localparam int CFG_W  = NUM_REQ + NUM_SUP + NUM_SNP + 2,
  localparam int REQ_IW = $clog2(NUM_REQ),
  localparam int SUP_IW = $clog2(NUM_SUP),
  localparam int SNP_IW = $clog2(NUM_SNP)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgWrEn,
  input  logic                     cfgWrSel,
  input  logic [CFG_W-1:0]         cfgWrData,
  input  logic                     cmpValid,
  input  logic [REQ_IW-1:0]        cmpReq,
  input  logic [SUP_IW-1:0]        cmpSup,
  input  logic [SNP_IW-1:0]        cmpSnp,
  input  logic [NUM_REQ*OCC_W-1:0] occIn,
  output logic [CNT_W-1:0]         count0,
  output logic [CNT_W-1:0]         count1,
  output logic                     cfgError
);
  logic [1:0][CFG_W-1:0] cfgBus;
  logic [1:0][CNT_W-1:0] countBus;
  ofrStrobes_t           strobes;

  ofr_ctrl #(.NUM_REQ(NUM_REQ), .NUM_SUP(NUM_SUP), .NUM_SNP(NUM_SNP)) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel),
    .cfgWrData(cfgWrData), .cfgOut(cfgBus), .strobes(strobes), .cfgError(cfgError)
  );

  ofr_datapath #(.NUM_REQ(NUM_REQ), .NUM_SUP(NUM_SUP), .NUM_SNP(NUM_SNP),
                 .OCC_W(OCC_W), .CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .cfgIn(cfgBus), .strobes(strobes),
    .cmpValid(cmpValid), .cmpReq(cmpReq), .cmpSup(cmpSup), .cmpSnp(cmpSnp),
    .occIn(occIn), .countOut(countBus)
  );

  assign count0 = countBus[0];
  assign count1 = countBus[1];
endmodule

// File: rtl/ofr_checker.sv
module ofr_checker #(
  parameter int NUM_REQ = 4,
  parameter int OCC_W   = 4,
  parameter int CNT_W   = 48
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWrEn,
  input logic             cfgWrSel,
  input logic             cmpValid,
  input logic             cfgError,
  input logic [CNT_W-1:0] count0,
  input logic [CNT_W-1:0] count1
);
  localparam logic [CNT_W-1:0] MAX_STEP = CNT_W'(NUM_REQ * ((1 << OCC_W) - 1));
  logic pastOk;
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;

  AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && cfgError |-> $past(cfgWrEn)); // R11

  AST_CLEAR_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && $past(cfgWrEn) && !cfgError |->
      ($past(cfgWrSel) ? count1 == '0 : count0 == '0)); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && !$past(cmpValid) && !$past(cfgWrEn) |-> count1 == $past(count1)); // R9

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && !$past(cfgWrEn) |-> (count1 - $past(count1)) <= CNT_W'(1)); // R3

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && !$past(cfgWrEn) |-> (count0 - $past(count0)) <= MAX_STEP); // R8
endmodule

bind ofr_latency_pair ofr_checker #(.NUM_REQ(NUM_REQ), .OCC_W(OCC_W), .CNT_W(CNT_W)) i_ofr_checker (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel),
  .cmpValid(cmpValid), .cfgError(cfgError), .count0(count0), .count1(count1)
);

// File: tb/test_ofr_latency_pair.sv
module test_ofr_latency_pair;
  localparam int NR = 4, NS = 4, NN = 4, OW = 4, CW = 48;
  localparam int CFW = NR + NS + NN + 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWrEn = 1'b0, cfgWrSel = 1'b0, cmpValid = 1'b0;
  logic [CFW-1:0] cfgWrData = '0;
  logic [1:0] cmpReq = '0, cmpSup = '0, cmpSnp = '0;
  logic [NR*OW-1:0] occIn = '0;
  logic [CW-1:0] count0, count1;
  logic cfgError;
  int checks = 0, fails = 0;
  logic [CW-1:0] exp0, exp1;

  always #5 clk = ~clk;

  ofr_latency_pair i_ofr_latency_pair (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel),
    .cfgWrData(cfgWrData), .cmpValid(cmpValid), .cmpReq(cmpReq),
    .cmpSup(cmpSup), .cmpSnp(cmpSnp), .occIn(occIn),
    .count0(count0), .count1(count1), .cfgError(cfgError)
  );

  function automatic logic [CFW-1:0] word(input logic [3:0] rq, sp, sn,
                                          input logic an, ot);
    return {ot, an, sn, sp, rq};
  endfunction

  function automatic logic hits(input logic [CFW-1:0] w, input int r, s, n);
    logic any;
    any = w[12] || (w[7:4] == 0 && w[11:8] == 0);
    return w[r] && (any || (w[4+s] && w[8+n]));
  endfunction

  task automatic chk(input string tag, input logic [CW-1:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // drive a write at negedge; returns at the next negedge with outputs updated
  task automatic wr(input logic sel, input logic [CFW-1:0] d);
    cfgWrEn = 1'b1; cfgWrSel = sel; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // sweep every completion against both counters' words
  task automatic sweep(input logic [CFW-1:0] w0, w1, input string tag);
    for (int r = 0; r < NR; r++)
      for (int s = 0; s < NS; s++)
        for (int n = 0; n < NN; n++) begin
          cmpValid = 1'b1; cmpReq = 2'(r); cmpSup = 2'(s); cmpSnp = 2'(n);
          @(negedge clk);
          if (hits(w0, r, s, n)) exp0++;
          if (hits(w1, r, s, n)) exp1++;
          chk({tag, " c0"}, count0, exp0);
          chk({tag, " c1"}, count1, exp1);
        end
    cmpValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [CFW-1:0] w0, w1;
    logic [CW-1:0] base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 count0", count0, 0);
    chk("R1 count1", count1, 0);
    chk("R1 cfgError", CW'(cfgError), 0);

    // R3/R4: masked match on counter 1, any-response on counter 0
    w0 = word(4'b1010, 4'b0000, 4'b0000, 1'b1, 1'b0);
    w1 = word(4'b0101, 4'b0011, 4'b0100, 1'b0, 1'b0);
    wr(0, w0); wr(1, w1);
    exp0 = 0; exp1 = 0;
    chk("R2 cleared", count0 + count1, 0);
    sweep(w0, w1, "R3R4");
    chk("R4 total", count0, 32);
    chk("R3 total", count1, 4);

    // R9: invalid completions ignored
    cmpValid = 1'b0; cmpReq = 2'd0; cmpSup = 2'd0; cmpSnp = 2'd2;
    repeat (4) @(negedge clk);
    chk("R9 c0", count0, exp0);
    chk("R9 c1", count1, exp1);

    // R5: both masks empty acts as any-response; R2 other counter untouched
    w1 = word(4'b0010, 4'b0000, 4'b0000, 1'b0, 1'b0);
    wr(1, w1);
    chk("R2 other kept", count0, exp0);
    chk("R2 sel cleared", count1, 0);
    exp1 = 0;
    sweep(w0, w1, "R5");
    chk("R5 total", count1, 16);

    // R6: any-response with supplier mask rejected
    wr(1, word(4'b1111, 4'b0001, 4'b0000, 1'b1, 1'b0));
    chk("R6 error", CW'(cfgError), 1);
    chk("R6 not cleared", count1, exp1);
    @(negedge clk);
    chk("R11 pulse", CW'(cfgError), 0);
    sweep(w0, w1, "R6 kept");

    // R7: outstanding with snoop, and outstanding on counter 1
    base = count0;
    wr(0, word(4'b0110, 4'b0000, 4'b0001, 1'b0, 1'b1));
    chk("R7 error", CW'(cfgError), 1);
    chk("R7 not cleared", count0, base);
    wr(1, word(4'b0110, 4'b0000, 4'b0000, 1'b0, 1'b1));
    chk("R7 sel1 error", CW'(cfgError), 1);
    chk("R7 sel1 kept", count1, exp1);
    sweep(w0, w1, "R7 kept");

    // R2: clear wins over same-cycle completion
    cmpValid = 1'b1; cmpReq = 2'd1;
    wr(1, w1);
    cmpValid = 1'b0;
    chk("R2 clear wins", count1, 0);

    // R8/R10: latency pair with occupancy on 0 and completions on 1
    wr(0, word(4'b0110, 4'b0000, 4'b0000, 1'b0, 1'b1));
    wr(1, word(4'b0110, 4'b0000, 4'b0000, 1'b1, 1'b0));
    chk("R8 cleared", count0, 0);
    exp0 = 0; exp1 = 0;
    for (int k = 0; k < 40; k++) begin
      occIn = {4'(k % 16), 4'((k * 3) % 16), 4'((k * 7) % 16), 4'(15 - k % 16)};
      cmpValid = (k % 3) != 0; cmpReq = 2'(k % 4); cmpSup = 2'(k % 2); cmpSnp = 2'd3;
      @(negedge clk);
      exp0 += CW'(((k * 7) % 16) + ((k * 3) % 16));
      if ((k % 3) != 0 && ((k % 4) == 1 || (k % 4) == 2)) exp1++;
      chk("R8 occupancy", count0, exp0);
      chk("R10 paired c1", count1, exp1);
    end
    occIn = '0; cmpValid = 1'b0;
    @(negedge clk);
    chk("R8 zero occ holds", count0, exp0);
    finish_run();
  end
endmodule